// File: doc/BRIEF.md
# Banked Debug Trace Output Multiplexer

This block puts one of several equal-width groups of internal signals onto a small set of debug output pins, where an external mixed-signal oscilloscope can watch them. The design clock is forwarded on a separate pin next to the data. A small serial port loads an 8-bit view command. That port runs on its own shift clock with a data line and an update strobe. Software can therefore change which group is visible while the monitored logic keeps running. Nothing in the monitored logic has to be rebuilt.

There are three output behaviours. State mode registers the selected group twice before the pins: once in a fabric flop and once in a pad flop. This keeps the load on user timing small. Timing mode drives the selected group to the pins without registers, so the scope samples it at its own rate. Training mode drives a toggling bit on one pin at a time and holds all other pins low. This lets host software find out which pin is wired to which scope channel. A command crosses into the design clock domain through a toggle handshake with a two-flop synchronizer, and it takes effect as one whole word.

Top module: `dbg_trace_mux`

## Requirements
- R1: After reset the view is group 0 in state mode. Two clock edges after reset is released, `dbg_data` shows group 0.
- R2: A command is 8 bits, shifted most significant bit first on rising edges of `jtck`. When `jupd` is high at a rising edge of `jtck`, the last 8 bits shifted are captured. Bits [7:6] select the mode (00 state, 01 timing, 10 training, 11 reserved). Bits [5:0] select the group. Mode and group take effect together within 8 design clock cycles.
- R3: In state mode, a change on `probe_bus` reaches `dbg_data` after exactly two rising edges of `clk`.
- R4: In timing mode, `dbg_data` follows the selected group of `probe_bus` with no clock edge in between.
- R5: A group index equal to or greater than `N_BANKS` drives `dbg_data` to all zeros, in both state mode and timing mode.
- R6: In training mode, only the active pin may be high. The active pin alternates between 1 and 0 on every `clk` cycle.
- R7: Loading a training command makes pin 0 the active pin. Each cycle with `train_step` high moves the active pin up by one. The step after pin `BANK_W-1` wraps back to pin 0.
- R8: `dbg_clk` follows `clk`. Registered output data changes only just after rising edges, so it is stable at falling edges.
- R9: The reserved mode code 11 behaves exactly like state mode, including the two-edge delay.
- R10: Groups that are not selected have no effect on `dbg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both clocks |
| probe_bus | input | BANK_W*N_BANKS | All groups concatenated; group g occupies bits [g*BANK_W +: BANK_W] |
| jtck | input | 1 | Shift clock of the serial command port |
| jtdi | input | 1 | Serial command data, most significant bit first |
| jupd | input | 1 | Update strobe, sampled on the rising edge of jtck |
| train_step | input | 1 | Advances the training pin; used only in training mode |
| dbg_data | output | BANK_W | Debug data pins |
| dbg_clk | output | 1 | Forwarded design clock |

## Verification
The bench computes a distinct byte for every group from the group number and a running step count. A wrong group, a swapped slice or a stale value therefore shows up as a wrong byte. The sweep covers both registered mode codes and both sides of the valid range, including index 63. In registered modes the bench samples once one edge after a data change and once two edges after it, which tells the registered path from the direct path. In timing mode it samples with no edge in between. Separate stimulus changes only the unselected groups. Training is swept across every pin and through the wrap. Each step checks that the other pins stay low and that the active pin toggles. A later training command checks that the active pin goes back to pin 0.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;

    localparam int CMD_W = 8;
    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        MODE_STATE  = 2'b00,
        MODE_TIMING = 2'b01,
        MODE_TRAIN  = 2'b10,
        MODE_RSVD   = 2'b11
    } out_mode_e;

    // Field order matches the command word: mode in [7:6], group in [5:0].
    typedef struct packed {
        out_mode_e              mode;
        logic [IDX_W-1:0]       bank;
    } view_cfg_t;

    function automatic logic bank_valid(logic [IDX_W-1:0] b, int n);
        return int'(b) < n;
    endfunction

    function automatic logic is_direct(out_mode_e m);
        return m == MODE_TIMING;
    endfunction

endpackage

// File: rtl/dbg_cmd_shift.sv
module dbg_cmd_shift
    import dbg_trace_pkg::*;
(
    input  logic      tck,
    input  logic      rst,
    input  logic      tdi,
    input  logic      upd,
    output view_cfg_t held,
    output logic      flag
);
    logic [CMD_W-1:0] sreg;

    always_ff @(posedge tck) begin
        if (rst) begin
            sreg <= '0;
            held <= '0;
            flag <= 1'b0;
        end else begin
            sreg <= {sreg[CMD_W-2:0], tdi};
            if (upd) begin
                held <= view_cfg_t'(sreg);
                flag <= ~flag;
            end
        end
    end
endmodule

// File: rtl/dbg_cfg_sync.sv
module dbg_cfg_sync
    import dbg_trace_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flag_in,
    input  view_cfg_t held_in,
    output view_cfg_t cfg,
    output logic      apply
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], flag_in};
    end

    assign apply = sync_q[2] ^ sync_q[1];

    // The whole word is loaded in one edge; held_in has been stable for
    // at least two design clocks by the time apply rises.
    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (apply) cfg <= held_in;
    end
endmodule

// File: rtl/dbg_lane_pipe.sv
module dbg_lane_pipe #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbg_trace_mux.sv
module dbg_trace_mux
    import dbg_trace_pkg::*;
#(
    parameter int BANK_W      = 8,
    parameter int N_BANKS     = 4,
    parameter int PIPE_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BANK_W*N_BANKS-1:0]   probe_bus,
    input  logic                        jtck,
    input  logic                        jtdi,
    input  logic                        jupd,
    input  logic                        train_step,
    output logic [BANK_W-1:0]           dbg_data,
    output logic                        dbg_clk
);
    localparam int SEL_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;
    localparam logic [SEL_W-1:0] LAST_PIN = SEL_W'(BANK_W - 1);

    view_cfg_t        held;
    logic             flag;
    view_cfg_t        cfg;
    logic             apply;
    logic [BANK_W-1:0] bank_word [N_BANKS];
    logic [BANK_W-1:0] sel_word;
    logic [BANK_W-1:0] train_word;
    logic [BANK_W-1:0] pipe_in;
    logic [BANK_W-1:0] pipe_q;
    logic [SEL_W-1:0]  train_pin;
    logic              phase;

    dbg_cmd_shift u_shift (
        .tck  (jtck),
        .rst  (rst),
        .tdi  (jtdi),
        .upd  (jupd),
        .held (held),
        .flag (flag)
    );

    dbg_cfg_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .flag_in (flag),
        .held_in (held),
        .cfg     (cfg),
        .apply   (apply)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        assign bank_word[g] = probe_bus[g*BANK_W +: BANK_W];
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < N_BANKS; i++) begin
            if (cfg.bank == IDX_W'(i)) sel_word = bank_word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || apply) begin
            train_pin <= '0;
        end else if (cfg.mode == MODE_TRAIN && train_step) begin
            train_pin <= (train_pin == LAST_PIN) ? '0 : train_pin + SEL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    assign train_word = phase ? (BANK_W'(1) << train_pin) : '0;
    assign pipe_in    = (cfg.mode == MODE_TRAIN) ? train_word : sel_word;

    dbg_lane_pipe #(.W(BANK_W), .STAGES(PIPE_STAGES)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (pipe_in),
        .q   (pipe_q)
    );

    assign dbg_data = is_direct(cfg.mode) ? sel_word : pipe_q;
    assign dbg_clk  = clk;
endmodule

// File: rtl/dbg_trace_mux_chk.sv
module dbg_trace_mux_chk
    import dbg_trace_pkg::*;
#(
    parameter int BANK_W  = 8,
    parameter int N_BANKS = 4,
    parameter int SEL_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input view_cfg_t         cfg,
    input logic              apply,
    input logic [BANK_W-1:0] sel_word,
    input logic [BANK_W-1:0] dbg_data,
    input logic [SEL_W-1:0]  train_pin
);
    view_cfg_t cfg_d1, cfg_d2;
    logic [1:0] age;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_d1 <= '0;
            cfg_d2 <= '0;
            age    <= '0;
        end else begin
            cfg_d1 <= cfg;
            cfg_d2 <= cfg_d1;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    assign settled = (age == 2'd3) && (cfg == cfg_d1) && (cfg_d1 == cfg_d2);

    // R1
    reset_view_chk: assert property (@(posedge clk) rst |=> (cfg == '0));

    // R2
    cfg_atomic_chk: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(cfg));

    // R3
    state_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && (cfg.mode == MODE_STATE || cfg.mode == MODE_RSVD))
        |-> dbg_data == $past(sel_word, 2));

    // R5
    range_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_TIMING && !bank_valid(cfg.bank, N_BANKS))
        |-> dbg_data == '0);

    // R6
    train_single_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && cfg.mode == MODE_TRAIN) |-> $onehot0(dbg_data));

    // R7
    train_pin_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(train_pin) < BANK_W);
endmodule

bind dbg_trace_mux dbg_trace_mux_chk #(
    .BANK_W  (BANK_W),
    .N_BANKS (N_BANKS),
    .SEL_W   (SEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .apply     (apply),
    .sel_word  (sel_word),
    .dbg_data  (dbg_data),
    .train_pin (train_pin)
);

// File: tb/dbg_trace_mux_test.sv
module dbg_trace_mux_test;
    localparam int BW = 8;
    localparam int NB = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [BW*NB-1:0] probe_bus = '0;
    logic            jtck = 1'b0;
    logic            jtdi = 1'b0;
    logic            jupd = 1'b0;
    logic            train_step = 1'b0;
    logic [BW-1:0]   dbg_data;
    logic            dbg_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int kstep = 0;

    dbg_trace_mux #(.BANK_W(BW), .N_BANKS(NB), .PIPE_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .probe_bus  (probe_bus),
        .jtck       (jtck),
        .jtdi       (jtdi),
        .jupd       (jupd),
        .train_step (train_step),
        .dbg_data   (dbg_data),
        .dbg_clk    (dbg_clk)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(int b, int k);
        return 8'((b * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_all(int k);
        for (int b = 0; b < NB; b++) probe_bus[b*BW +: BW] = pat(b, k);
    endtask

    task automatic send_cmd(logic [1:0] mode, logic [5:0] bank);
        logic [7:0] w;
        w = {mode, bank};
        for (int i = 7; i >= 0; i--) begin
            jtdi = w[i];
            #10 jtck = 1'b1;
            #10 jtck = 1'b0;
        end
        jupd = 1'b1;
        #10 jtck = 1'b1;
        #10 jtck = 1'b0;
        jupd = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] a, b2, exp;
        load_all(0);
        for (int i = 0; i < 4; i++) begin
            #10 jtck = 1'b1;
            #10 jtck = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset view group0", dbg_data, pat(0, 0));
        chk("R8 dbg_clk low at falling edge", {7'b0, dbg_clk}, 8'd0);
        @(posedge clk);
        #1 chk("R8 dbg_clk high after rising edge", {7'b0, dbg_clk}, 8'd1);

        // Registered modes: 00 state, 11 reserved
        for (int m = 0; m < 2; m++) begin
            for (int bi = 0; bi < 9; bi++) begin
                int bank;
                logic [1:0] md;
                bank = (bi == 8) ? 63 : bi;
                md = (m == 0) ? 2'b00 : 2'b11;
                send_cmd(md, 6'(bank));
                kstep++;
                @(negedge clk) load_all(kstep);
                repeat (3) @(negedge clk);
                exp = (bank < NB) ? pat(bank, kstep) : 8'h00;
                chk(m == 0 ? "R2 state command applied" : "R9 reserved code applied", dbg_data, exp);
                load_all(kstep + 1);
                @(negedge clk);
                chk(m == 0 ? "R3 one edge keeps old" : "R9 one edge keeps old", dbg_data, exp);
                @(negedge clk);
                exp = (bank < NB) ? pat(bank, kstep + 1) : 8'h00;
                chk(bank < NB ? "R3 two edges show new" : "R5 out of range zero (state)", dbg_data, exp);
                #5 chk("R8 stable after rising edge", dbg_data, exp);
                @(negedge clk);
                for (int o = 0; o < NB; o++)
                    if (o != bank) probe_bus[o*BW +: BW] = pat(o, kstep + 9);
                repeat (3) @(negedge clk);
                chk("R10 unselected groups ignored", dbg_data, exp);
                kstep += 2;
            end
        end

        // Timing mode
        for (int bi = 0; bi < 9; bi++) begin
            int bank;
            bank = (bi == 8) ? 63 : bi;
            send_cmd(2'b01, 6'(bank));
            kstep++;
            load_all(kstep);
            #1;
            exp = (bank < NB) ? pat(bank, kstep) : 8'h00;
            chk(bank < NB ? "R4 direct path same cycle" : "R5 out of range zero (timing)", dbg_data, exp);
            @(negedge clk);
            kstep++;
            load_all(kstep);
            #1;
            exp = (bank < NB) ? pat(bank, kstep) : 8'h00;
            chk("R4 direct path follows change", dbg_data, exp);
        end

        // Training mode
        send_cmd(2'b10, 6'd0);
        repeat (3) @(negedge clk);
        for (int s = 0; s <= BW; s++) begin
            int p;
            logic [7:0] mask;
            p = s % BW;
            mask = 8'(1 << p);
            a = dbg_data;
            @(negedge clk);
            b2 = dbg_data;
            chk("R6 other pins low (first sample)", a & ~mask, 8'h00);
            chk("R6 other pins low (second sample)", b2 & ~mask, 8'h00);
            chk("R7 active pin toggles", {7'b0, a[p] ^ b2[p]}, 8'd1);
            train_step = 1'b1;
            @(negedge clk);
            train_step = 1'b0;
            repeat (3) @(negedge clk);
        end
        // advance away from pin 0, then reload training: back to pin 0
        train_step = 1'b1;
        @(negedge clk);
        train_step = 1'b0;
        send_cmd(2'b10, 6'd5);
        repeat (3) @(negedge clk);
        a = dbg_data;
        @(negedge clk);
        b2 = dbg_data;
        chk("R7 reload restarts at pin 0", (a | b2), 8'h01);

        finish_run();
    end
endmodule